// File: doc/BRIEF.md
# Bit-Slice Ripple ALU with Subtraction

This block is a purely combinational arithmetic and logic unit of configurable width, 32 bits by default. It is built from identical one-bit slices. Each slice makes three candidate outputs: the AND of its operand bits, their OR, and a full-adder sum. A two-bit operation select goes to every slice and picks one of these outputs. The carry of each slice feeds the next slice up, so the slices form a single ripple chain. The carry leaving the top slice is the unit's carry-out.

Subtraction has no dedicated unit. A per-slice invert control swaps each B bit for its complement. With this control set and the chain's carry-in forced to one, the adder computes A + ~B + 1, which equals A − B in two's complement. The invert control acts before the output select, so it also changes the AND and OR results. The carry-out comes from the adder chain whatever operation is selected.

Top module: `ripple_alu`

## Requirements
- R1: With op_sel = 0, result equals opa AND B', where B' is ~opb when b_inv = 1 and opb when b_inv = 0.
- R2: With op_sel = 1, result equals opa OR B', with B' defined as in R1.
- R3: With op_sel = 2 and b_inv = 0, {carry_out, result} equals opa + opb + carry_in, evaluated at WIDTH+1 bits unsigned.
- R4: With op_sel = 2, b_inv = 1 and carry_in = 1, result equals opa − opb modulo 2^WIDTH, and carry_out is 1 exactly when opa ≥ opb as unsigned numbers.
- R5: With op_sel = 2, b_inv = 1 and carry_in = 0, {carry_out, result} equals opa + ~opb at WIDTH+1 bits, so result is opa − opb − 1.
- R6: With op_sel = 3, result is all zeros.
- R7: carry_out always equals the carry of opa + B' + carry_in, for every value of op_sel, including the logic operations and code 3.
- R8: A carry entering at slice 0 propagates through every slice: opa = all ones, opb = 0, b_inv = 0, carry_in = 1, op_sel = 2 gives result 0 and carry_out 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | WIDTH | First operand |
| opb | input | WIDTH | Second operand, optionally inverted per slice |
| op_sel | input | 2 | Output select: 0 AND, 1 OR, 2 adder sum, 3 zero |
| b_inv | input | 1 | Use the complement of opb in every slice |
| carry_in | input | 1 | Carry into slice 0 |
| result | output | WIDTH | Selected slice outputs |
| carry_out | output | 1 | Carry out of the top slice |

## Verification
The AND and OR checks use interleaved byte and nibble masks, with the invert control both low and high. This shows whether the inversion sits before the output select or only on the adder path. The arithmetic checks use small values, equal operands, operands in swapped order, and all-ones and sign-bit operands. These separate a correct ripple from a chain that drops or truncates the carry, and they pin down how the carry-out sense flips between addition and subtraction. Random operands under every combination of select, invert and carry-in then compare both outputs against wide unsigned arithmetic. These include the invert-without-carry case and the zero code.

// File: rtl/rca_pkg.sv
package rca_pkg;

  typedef enum logic [1:0] {
    SEL_AND  = 2'd0,
    SEL_OR   = 2'd1,
    SEL_SUM  = 2'd2,
    SEL_ZERO = 2'd3
  } alu_sel_e;

  // One-bit full adder: returns {carry, sum}.
  function automatic logic [1:0] fa_bit(input logic x, input logic y, input logic c);
    logic s;
    logic co;
    s  = x ^ y ^ c;
    co = (x & y) | (c & (x ^ y));
    return {co, s};
  endfunction

  // Conditional complement of an operand bit.
  function automatic logic cond_inv(input logic v, input logic inv);
    return inv ? ~v : v;
  endfunction

endpackage

// File: rtl/rca_full_adder.sv
module rca_full_adder (
  input  logic x,
  input  logic y,
  input  logic cin,
  output logic sum,
  output logic cout
);
  import rca_pkg::*;

  logic [1:0] pair;

  always_comb begin
    pair = fa_bit(x, y, cin);
  end

  assign sum  = pair[0];
  assign cout = pair[1];

endmodule

// File: rtl/rca_slice_mux.sv
module rca_slice_mux (
  input  logic [1:0] sel,
  input  logic       and_in,
  input  logic       or_in,
  input  logic       sum_in,
  output logic       y
);
  import rca_pkg::*;

  always_comb begin
    unique case (alu_sel_e'(sel))
      SEL_AND:  y = and_in;
      SEL_OR:   y = or_in;
      SEL_SUM:  y = sum_in;
      SEL_ZERO: y = 1'b0;
      default:  y = 1'b0;
    endcase
  end

endmodule

// File: rtl/rca_bit_slice.sv
module rca_bit_slice (
  input  logic       a,
  input  logic       b,
  input  logic       b_inv,
  input  logic       cin,
  input  logic [1:0] sel,
  output logic       y,
  output logic       cout
);
  import rca_pkg::*;

  logic b_eff;
  logic and_bit;
  logic or_bit;
  logic sum_bit;

  assign b_eff   = cond_inv(b, b_inv);
  assign and_bit = a & b_eff;
  assign or_bit  = a | b_eff;

  rca_full_adder u_fa (
    .x    (a),
    .y    (b_eff),
    .cin  (cin),
    .sum  (sum_bit),
    .cout (cout)
  );

  rca_slice_mux u_mux (
    .sel    (sel),
    .and_in (and_bit),
    .or_in  (or_bit),
    .sum_in (sum_bit),
    .y      (y)
  );

endmodule

// File: rtl/ripple_alu.sv
module ripple_alu #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic [1:0]       op_sel,
  input  logic             b_inv,
  input  logic             carry_in,
  output logic [WIDTH-1:0] result,
  output logic             carry_out
);
  import rca_pkg::*;

  localparam int XW = WIDTH + 1;

  logic [WIDTH:0] chain;

  assign chain[0] = carry_in;

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    rca_bit_slice u_slice (
      .a     (opa[i]),
      .b     (opb[i]),
      .b_inv (b_inv),
      .cin   (chain[i]),
      .sel   (op_sel),
      .y     (result[i]),
      .cout  (chain[i+1])
    );
  end

  assign carry_out = chain[WIDTH];

  // Named events for the checks below.
  logic sel_and;
  logic sel_or;
  logic sel_sum;
  logic sel_zero;
  logic add_mode;
  logic sub_mode;
  logic subm1_mode;

  assign sel_and    = (op_sel == 2'd0);
  assign sel_or     = (op_sel == 2'd1);
  assign sel_sum    = (op_sel == 2'd2);
  assign sel_zero   = (op_sel == 2'd3);
  assign add_mode   = sel_sum && !b_inv;
  assign sub_mode   = sel_sum && b_inv && carry_in;
  assign subm1_mode = sel_sum && b_inv && !carry_in;

  logic [WIDTH-1:0] ref_b;
  logic [XW-1:0]    ref_wide;

  always_comb begin
    ref_b    = b_inv ? ~opb : opb;
    ref_wide = XW'(opa) + XW'(ref_b) + XW'(carry_in);
  end

  always_comb begin
    if (sel_and) begin
      p_and_r1: assert (result == (opa & ref_b)) else $error("R1 AND mismatch");
    end
    if (sel_or) begin
      p_or_r2: assert (result == (opa | ref_b)) else $error("R2 OR mismatch");
    end
    if (add_mode) begin
      p_add_r3: assert ({carry_out, result} == (XW'(opa) + XW'(opb) + XW'(carry_in)))
        else $error("R3 add mismatch");
    end
    if (sub_mode) begin
      p_sub_r4: assert ((result == opa - opb) && (carry_out == (opa >= opb)))
        else $error("R4 subtract mismatch");
    end
    if (subm1_mode) begin
      p_subm1_r5: assert (result == opa - opb - WIDTH'(1)) else $error("R5 mismatch");
    end
    if (sel_zero) begin
      p_zero_r6: assert (result == '0) else $error("R6 zero code mismatch");
    end
    p_cout_r7: assert (carry_out == ref_wide[WIDTH]) else $error("R7 carry mismatch");
  end

endmodule

// File: tb/ripple_alu_tb.sv
module ripple_alu_tb;

  localparam int W = 32;

  typedef struct packed {
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic [1:0]   sel;
    logic         inv;
    logic         ci;
    logic [W-1:0] exp_res;
    logic         exp_co;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{32'hFFFF0000, 32'h0F0F0F0F, 2'd0, 1'b0, 1'b0, 32'h0F0F0000, 1'b1}, // R1
    '{32'hFFFF0000, 32'h0F0F0F0F, 2'd1, 1'b0, 1'b0, 32'hFFFF0F0F, 1'b1}, // R2
    '{32'h00000005, 32'h00000003, 2'd2, 1'b0, 1'b0, 32'h00000008, 1'b0}, // R3
    '{32'hFFFFFFFF, 32'h00000001, 2'd2, 1'b0, 1'b0, 32'h00000000, 1'b1}, // R3
    '{32'hFFFFFFFF, 32'h00000000, 2'd2, 1'b0, 1'b1, 32'h00000000, 1'b1}, // R8
    '{32'h00000007, 32'h00000002, 2'd2, 1'b1, 1'b1, 32'h00000005, 1'b1}, // R4
    '{32'h00000002, 32'h00000007, 2'd2, 1'b1, 1'b1, 32'hFFFFFFFB, 1'b0}, // R4
    '{32'h00000005, 32'h00000005, 2'd2, 1'b1, 1'b1, 32'h00000000, 1'b1}, // R4
    '{32'h0000000A, 32'h00000003, 2'd2, 1'b1, 1'b0, 32'h00000006, 1'b1}, // R5
    '{32'hFFFF0000, 32'h0F0F0F0F, 2'd0, 1'b1, 1'b0, 32'hF0F00000, 1'b1}, // R1
    '{32'h0000FFFF, 32'h0F0F0F0F, 2'd1, 1'b1, 1'b0, 32'hF0F0FFFF, 1'b0}, // R2
    '{32'h12345678, 32'h00000001, 2'd3, 1'b0, 1'b0, 32'h00000000, 1'b0}, // R6
    '{32'hFFFFFFFF, 32'h00000001, 2'd3, 1'b0, 1'b0, 32'h00000000, 1'b1}, // R6 R7
    '{32'h80000000, 32'h80000000, 2'd2, 1'b0, 1'b0, 32'h00000000, 1'b1}, // R3
    '{32'h00000000, 32'h00000001, 2'd2, 1'b1, 1'b1, 32'hFFFFFFFF, 1'b0}  // R4
  };

  logic         clk = 1'b0;
  logic [W-1:0] opa = '0;
  logic [W-1:0] opb = '0;
  logic [1:0]   op_sel = 2'd0;
  logic         b_inv = 1'b0;
  logic         carry_in = 1'b0;
  logic [W-1:0] result;
  logic         carry_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  ripple_alu #(.WIDTH(W)) u_dut (
    .opa       (opa),
    .opb       (opb),
    .op_sel    (op_sel),
    .b_inv     (b_inv),
    .carry_in  (carry_in),
    .result    (result),
    .carry_out (carry_out)
  );

  // Independent model: operand bits processed as whole-word arithmetic.
  function automatic logic [W:0] model(input logic [W-1:0] a, input logic [W-1:0] b,
                                        input logic [1:0] s, input logic inv, input logic ci);
    logic [W-1:0] bb;
    logic [W:0]   tot;
    logic [W-1:0] r;
    bb  = inv ? (~b) : b;
    tot = {1'b0, a} + {1'b0, bb} + {{W{1'b0}}, ci};
    case (s)
      2'd0:    r = a & bb;
      2'd1:    r = a | bb;
      2'd2:    r = tot[W-1:0];
      default: r = '0;
    endcase
    return {tot[W], r};
  endfunction

  task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic [1:0] s, input logic inv, input logic ci);
    @(posedge clk);
    opa = a; opb = b; op_sel = s; b_inv = inv; carry_in = ci;
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [W-1:0] er, input logic eco);
    checks++;
    if (result !== er || carry_out !== eco) begin
      fails++;
      $display("FAIL %s: a=%h b=%h sel=%0d inv=%b ci=%b got res=%h co=%b expected res=%h co=%b",
               req, opa, opb, op_sel, b_inv, carry_in, result, carry_out, er, eco);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: expired, got done=0 expected done=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : stim
    // Initial state: all-zero inputs, AND select (R1, R7).
    @(negedge clk);
    check("R1 idle", 32'h0, 1'b0);

    // Vector table walk.
    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].a, VECS[i].b, VECS[i].sel, VECS[i].inv, VECS[i].ci);
      check("R1-R8 table", VECS[i].exp_res, VECS[i].exp_co);
    end

    // Directed corner: carry through every slice (R8).
    apply('1, '0, 2'd2, 1'b0, 1'b1);
    check("R8 full ripple", '0, 1'b1);
    // Subtract with max minus max and zero minus max (R4).
    apply('1, '1, 2'd2, 1'b1, 1'b1);
    check("R4 equal max", '0, 1'b1);
    apply('0, '1, 2'd2, 1'b1, 1'b1);
    check("R4 zero minus max", 32'h1, 1'b0);
    // Code 3 still reports carry of inverted add (R6 R7).
    apply(32'h00000004, 32'h00000003, 2'd3, 1'b1, 1'b1);
    check("R6 R7 zero code carry", '0, 1'b1);

    // Random sweep across all controls (R1 R2 R3 R4 R5 R6 R7).
    for (int k = 0; k < 400; k++) begin
      logic [W-1:0] ra;
      logic [W-1:0] rb;
      logic [W:0]   m;
      ra = $urandom;
      rb = $urandom;
      if (k % 16 == 0) rb = ra;
      apply(ra, rb, 2'(k % 4), 1'((k / 4) % 2), 1'((k / 8) % 2));
      m = model(ra, rb, 2'(k % 4), 1'((k / 4) % 2), 1'((k / 8) % 2));
      check("R1 R2 R3 R4 R5 R6 R7 random", m[W-1:0], m[W]);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule